// File: doc/BRIEF.md
# Multi-Mode Test Observation Register

This block is a row of flip-flops placed at the output of a combinational logic cloud. A two-bit mode code selects what the row does. It can capture the logic outputs like a plain pipeline register. It can act as a serial shift chain so that a tester can load and unload its contents. It can clear itself. Its last mode is a self-test mode, in which linear feedback makes it produce pseudo-random patterns and fold the parallel inputs into a compact signature.

A separate seed input forces every flop to one. This gives the feedback path a non-zero start, because an all-zero state never leaves a pure linear feedback loop. A typical self-test run works as follows. Pulse the seed input, hold the self-test mode while the logic under test drives the parallel inputs, then switch to scan mode and shift the signature out through the serial output. The width and the feedback tap mask are parameters. With the defaults the row is three bits wide and the taps are bits 2 and 0.

Top module: `bilbo_reg`

## Requirements
- R1: When mode is 2'b11 (normal) and seed is low, every flop loads its own parallel input bit on the next rising clock edge.
- R2: When mode is 2'b00 (scan) and seed is low, each clock edge shifts the contents one place toward the MSB, and scan_in enters bit 0.
- R3: When mode is 2'b01 (self-test) and seed is low, the next state bit 0 is din[0] XOR the feedback bit. Every higher bit i is din[i] XOR the old bit i-1. The feedback bit is the XOR of the state bits selected by the tap mask (bits 2 and 0 by default).
- R4: When din is held at 0 in self-test mode, a 3-bit row seeded with 111 steps through 110, 101, 010, 100, 001, 011 and then returns to 111. The period is 7, and a non-zero state never becomes zero.
- R5: When mode is 2'b10 (clear) and seed is low, every flop becomes 0 on the next clock edge.
- R6: A high seed input loads all ones on the next clock edge and takes priority over every mode code.
- R7: scan_out always equals the current MSB of the register, in every mode.
- R8: A mode change acts at the next clock edge, and the contents survive a switch from self-test to scan. The first scan_out value after the switch is the signature's MSB, then its lower bits follow one per clock.
- R9: An input stream applied in self-test mode from a seeded start yields a signature that differs when a single bit of a single input word is inverted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| mode | input | 2 | 00 scan, 01 self-test, 10 clear, 11 normal |
| seed | input | 1 | Loads all ones when high; overrides mode |
| din | input | W | Parallel word from the logic under test |
| scan_in | input | 1 | Serial data entering bit 0 in scan mode |
| q | output | W | Current register contents |
| scan_out | output | 1 | Serial output, the register MSB |

## Verification
The hardest case to reach is a signature that is read only through the serial path. To reach it, the row must be seeded, then run through a known multi-word stream in self-test mode, then switched to scan mode without losing a bit. The stimulus drives that whole sequence and reads the result bit by bit on scan_out. It then repeats the run with one input bit inverted, to show that the signature separates the two streams. A behavioural model tracks the row on every clock. It checks the full pattern-generator cycle and a long mix of random modes and inputs.

// File: rtl/bilbo_reg.sv
module bilbo_reg #(
  parameter int W = 3,
  parameter logic [W-1:0] TAPS = 3'b101
) (
  input  logic         clk,
  input  logic [1:0]   mode,
  input  logic         seed,
  input  logic [W-1:0] din,
  input  logic         scan_in,
  output logic [W-1:0] q,
  output logic         scan_out
);
  localparam logic [1:0] M_SCAN = 2'b00;
  localparam logic [1:0] M_TEST = 2'b01;
  localparam logic [1:0] M_CLR  = 2'b10;

  logic         fb;
  logic [W-1:0] shifted;
  logic [W-1:0] nxt;

  assign fb       = ^(q & TAPS);
  assign shifted  = {q[W-2:0], (mode == M_TEST) ? fb : scan_in};
  assign scan_out = q[W-1];

  always_comb begin
    case (mode)
      M_SCAN:  nxt = shifted;
      M_TEST:  nxt = shifted ^ din;
      M_CLR:   nxt = '0;
      default: nxt = din;
    endcase
  end

  always_ff @(posedge clk) q <= seed ? '1 : nxt;

  // assertions become active once the row holds a known value
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | seed | (mode == M_CLR);

  p_normal_load_r1: assert property (@(posedge clk) disable iff (!armed)
    (mode == 2'b11 && !seed) |=> q == $past(din));

  p_scan_shift_r2: assert property (@(posedge clk) disable iff (!armed)
    (mode == 2'b00 && !seed) |=> q == {$past(q[W-2:0]), $past(scan_in)});

  p_test_step_r3: assert property (@(posedge clk) disable iff (!armed)
    (mode == 2'b01 && !seed) |=>
      q == ($past(din) ^ {$past(q[W-2:0]), $past(^(q & TAPS))}));

  p_lfsr_nonzero_r4: assert property (@(posedge clk) disable iff (!armed)
    (mode == 2'b01 && !seed && din == '0 && q != '0) |=> q != '0);

  p_clear_r5: assert property (@(posedge clk) disable iff (!armed)
    (mode == 2'b10 && !seed) |=> q == '0);

  p_seed_ones_r6: assert property (@(posedge clk) disable iff (!armed)
    seed |=> q == '1);
endmodule

// File: tb/bilbo_reg_tb.sv
module bilbo_reg_tb;
  localparam int W = 3;

  logic         clk = 1'b0;
  logic [1:0]   mode = 2'b10;
  logic         seed = 1'b0;
  logic [W-1:0] din = '0;
  logic         scan_in = 1'b0;
  logic [W-1:0] q;
  logic         scan_out;

  int nchk = 0;
  int nfail = 0;
  logic [W-1:0] exp_q = '0;

  always #10 clk = ~clk;

  bilbo_reg #(.W(W), .TAPS(3'b101)) u_dut (
    .clk(clk), .mode(mode), .seed(seed), .din(din),
    .scan_in(scan_in), .q(q), .scan_out(scan_out)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] expv);
    nchk++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s: got %b expected %b", tag, act, expv);
    end
  endtask

  function automatic logic [W-1:0] model(input logic [W-1:0] cur, input logic [1:0] m,
                                         input logic s, input logic [W-1:0] d, input logic si);
    logic [W-1:0] t;
    logic in0;
    if (s) return '1;
    if (m == 2'b10) return '0;
    if (m == 2'b11) return d;
    in0 = (m == 2'b01) ? (cur[2] ^ cur[0]) : si;
    for (int i = W - 1; i > 0; i--) t[i] = cur[i-1];
    t[0] = in0;
    if (m == 2'b01) t = t ^ d;
    return t;
  endfunction

  task automatic step(input logic [1:0] m, input logic s, input logic [W-1:0] d,
                      input logic si, input string tag);
    mode = m; seed = s; din = d; scan_in = si;
    @(posedge clk);
    exp_q = model(exp_q, m, s, d, si);
    @(negedge clk);
    check(tag, q, exp_q);
    check("R7 scan_out", {2'b00, scan_out}, {2'b00, exp_q[W-1]});
  endtask

  task automatic sig_run(input int flip, output logic [W-1:0] sig);
    step(2'b01, 1'b1, '0, 1'b0, "R6 seed");
    for (int k = 0; k < 10; k++) begin
      logic [W-1:0] w;
      w = 3'((k * 5 + 3) % 8);
      if (k == flip) w = w ^ 3'b010;
      step(2'b01, 1'b0, w, 1'b0, "R3 stream");
    end
    sig = q;
  endtask

  localparam logic [W-1:0] SEQ [7] = '{3'b110, 3'b101, 3'b010, 3'b100, 3'b001, 3'b011, 3'b111};

  initial begin
    logic [W-1:0] sig_a, sig_b;
    step(2'b10, 1'b0, 3'b111, 1'b1, "R5 clear");
    check("R5 reset value", q, 3'b000);

    step(2'b11, 1'b0, 3'b101, 1'b0, "R1 normal");
    step(2'b11, 1'b0, 3'b010, 1'b1, "R1 normal");
    step(2'b11, 1'b0, 3'b111, 1'b0, "R1 normal");
    check("R1 capture", q, 3'b111);

    step(2'b10, 1'b0, 3'b000, 1'b0, "R5 clear");
    step(2'b00, 1'b0, 3'b111, 1'b1, "R2 scan");
    step(2'b00, 1'b0, 3'b000, 1'b0, "R2 scan");
    step(2'b00, 1'b0, 3'b111, 1'b1, "R2 scan");
    check("R2 shifted word", q, 3'b101);

    step(2'b10, 1'b1, 3'b000, 1'b0, "R6 seed over clear");
    check("R6 ones", q, 3'b111);
    step(2'b10, 1'b0, 3'b000, 1'b0, "R5 clear");
    step(2'b00, 1'b1, 3'b000, 1'b0, "R6 seed over scan");
    check("R6 ones", q, 3'b111);

    for (int k = 0; k < 7; k++) begin
      step(2'b01, 1'b0, 3'b000, 1'b0, "R4 lfsr");
      check("R4 sequence", q, SEQ[k]);
    end

    sig_run(-1, sig_a);
    check("R8 signature msb", {2'b00, scan_out}, {2'b00, sig_a[2]});
    step(2'b00, 1'b0, '0, 1'b0, "R8 unload");
    check("R8 signature bit1", {2'b00, scan_out}, {2'b00, sig_a[1]});
    step(2'b00, 1'b0, '0, 1'b0, "R8 unload");
    check("R8 signature bit0", {2'b00, scan_out}, {2'b00, sig_a[0]});

    sig_run(4, sig_b);
    nchk++;
    if (sig_a == sig_b) begin
      nfail++;
      $display("FAIL R9: got %b expected a value other than %b", sig_b, sig_a);
    end

    for (int k = 0; k < 60; k++) begin
      logic [1:0] m;
      m = 2'($urandom_range(0, 3));
      step(m, ($urandom_range(0, 15) == 0), 3'($urandom_range(0, 7)),
           1'($urandom_range(0, 1)), "R3 random mix");
    end

    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    #4000000;
    nchk++;
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule